// File: doc/BRIEF.md
# Address Error Exception Sequencer

This block takes control of a processor core when the core reports a misaligned or illegal access. It does not act at once. It waits until the offending bus cycle has ended and the running instruction has retired. Then it saves the return state on the stack through a plain word-wide memory port, with every access paced by a ready handshake. It adjusts the interrupt mask and trace bits, fetches the handler entry address from a fixed vector slot, and hands that address back to the core with a one-cycle load strobe.

When the sequence begins, the block also sends stop requests to the transfer engines. It raises an error flag in the transfer controller and another in DMA channel 0, and it clears the enable of every DMA channel. While the sequence is running, any further address error is dropped. This keeps the stacking writes from setting off the sequence again without end. If the stack pointer is odd at entry, the block raises a flag, because the saved words cannot be trusted in that case.

Top module: `addr_fault_seq`

## Requirements
- R1: After reset, busy, pc_load, mem_wr_en, mem_rd_en, xfer_err_set, dma0_err_set and every dma_en_clr bit are 0.
- R2: After fault_req is accepted, busy is 1 from the next cycle on. No memory access and no halt pulse happens until bus_end and insn_end have each been high in some cycle after the fault cycle. The two may come in different cycles. Stacking starts in the cycle after the later of the two.
- R3: Stacking writes three words, each at the stack pointer pre-decremented by 2 (stack pointer SP at entry). pc_in[15:0] goes to SP-2. pc_in[31:16] goes to SP-4. {ccr_in, exr_in} goes to SP-6, with ccr_in in bits 15:8. Reads and writes are never requested together.
- R4: Each access keeps its request, address and write data stable until mem_ready is high. The access completes in the cycle where mem_ready is high.
- R5: In the first stacking cycle, and only then, xfer_err_set, dma0_err_set and all dma_en_clr bits are 1 for exactly one cycle.
- R6: At pc_load, ccr_out equals the entry CCR with bit 7 (interrupt mask I) set. All other bits are kept, including bit 6 (UI).
- R7: At pc_load, exr_out equals the entry EXR with bit 7 (trace T) cleared. When intr_mode2=0, bits 2:0 (mask) are kept. When intr_mode2=1, bits 2:0 are 3'b111. Bits 6:3 are kept.
- R8: After the three writes, the block reads the high handler word from VEC_ADDR (default 16'h0010) and then the low word from VEC_ADDR+2.
- R9: pc_load is a one-cycle pulse in the cycle after the low-word read completes. In that cycle pc_out = {high word, low word}, sp_out = SP-6, and busy is 0.
- R10: fault_req is ignored while busy is 1. Each accepted fault gives exactly five memory accesses and one pc_load.
- R11: sp_odd equals bit 0 of the SP captured at stacking start. It holds from the first stacking cycle until the next sequence starts. The sequence still completes when SP is odd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fault_req | input | 1 | Address error reported by the core |
| bus_end | input | 1 | Faulting bus cycle has ended |
| insn_end | input | 1 | Current instruction has completed |
| intr_mode2 | input | 1 | 1 selects interrupt control mode 2, 0 selects mode 0 |
| pc_in | input | 32 | Program counter to save |
| ccr_in | input | 8 | Condition code register to save |
| exr_in | input | 8 | Extended status register to save |
| sp_in | input | 16 | Stack pointer at entry |
| mem_wr_en | output | 1 | Stack write request |
| mem_rd_en | output | 1 | Vector read request |
| mem_addr | output | 16 | Access byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |
| busy | output | 1 | Sequence in progress |
| pc_out | output | 32 | Handler start address |
| pc_load | output | 1 | pc_out is valid; core loads its PC |
| ccr_out | output | 8 | Updated CCR |
| exr_out | output | 8 | Updated EXR |
| sp_out | output | 16 | Stack pointer after stacking |
| sp_odd | output | 1 | Entry stack pointer was odd |
| xfer_err_set | output | 1 | Set error flag in transfer controller |
| dma0_err_set | output | 1 | Set error flag in DMA channel 0 |
| dma_en_clr | output | 4 | Clear enable of each DMA channel |

## Verification
The hardest case to reach is a nested fault. It has to arrive while the block is still waiting for completion, or in the middle of a stalled stacking write, and above all in the very cycle the last vector read is accepted, just before busy drops. The bench holds mem_ready low for several cycles per access and raises fault_req on every other busy cycle up to the cycle before pc_load. It then checks that no sixth access and no second pc_load appear. The two completion inputs are also delivered in separate cycles, in both orders, to show that the block starts only after the later one.

// File: rtl/addr_fault_pkg.sv
package addr_fault_pkg;
  localparam int WORD_W     = 16;
  localparam int ADDR_W     = 16;
  localparam int SR_W       = 8;
  localparam int WORD_BYTES = WORD_W / 8;

  typedef enum logic [1:0] {GATE_IDLE, GATE_WAIT, GATE_RUN} gate_st_t;
  typedef enum logic [1:0] {ENG_IDLE, ENG_PUSH, ENG_FETCH} eng_st_t;

  // next stack slot: pre-decrement by one word
  function automatic logic [ADDR_W-1:0] push_slot(input logic [ADDR_W-1:0] sp_now);
    return sp_now - ADDR_W'(WORD_BYTES);
  endfunction

  // k-th word of the vector entry
  function automatic logic [ADDR_W-1:0] vec_slot(input logic [ADDR_W-1:0] base,
                                                 input int unsigned k);
    return base + ADDR_W'(k * WORD_BYTES);
  endfunction

  // CCR after entry: mask bit 7 set, rest kept
  function automatic logic [SR_W-1:0] ccr_after(input logic [SR_W-1:0] c);
    logic [SR_W-1:0] r;
    r    = c;
    r[7] = 1'b1;
    return r;
  endfunction

  // EXR after entry: trace bit 7 cleared, mask 2:0 forced in mode 2
  function automatic logic [SR_W-1:0] exr_after(input logic [SR_W-1:0] e,
                                                input logic mode2);
    logic [SR_W-1:0] r;
    r    = e;
    r[7] = 1'b0;
    if (mode2) r[2:0] = 3'b111;
    return r;
  endfunction
endpackage

// File: rtl/afs_entry_gate.sv
module afs_entry_gate
  import addr_fault_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fault_req,
  input  logic bus_end,
  input  logic insn_end,
  input  logic seq_end,
  output logic go,
  output logic busy
);
  gate_st_t st_q, st_d;
  logic bus_seen_q, insn_seen_q;
  logic bus_ok, insn_ok;

  assign bus_ok  = bus_seen_q | bus_end;
  assign insn_ok = insn_seen_q | insn_end;
  assign go      = (st_q == GATE_WAIT) && bus_ok && insn_ok;
  assign busy    = (st_q != GATE_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GATE_IDLE: if (fault_req) st_d = GATE_WAIT;
      GATE_WAIT: if (go)        st_d = GATE_RUN;
      GATE_RUN:  if (seq_end)   st_d = GATE_IDLE;
      default:                  st_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= GATE_IDLE;
      bus_seen_q  <= 1'b0;
      insn_seen_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == GATE_WAIT && !go) begin
        bus_seen_q  <= bus_ok;
        insn_seen_q <= insn_ok;
      end else begin
        bus_seen_q  <= 1'b0;
        insn_seen_q <= 1'b0;
      end
    end
  end

  // R10
  nest_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GATE_RUN && !seq_end) |=> (st_q == GATE_RUN));

  // R2
  go_needs_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GATE_IDLE && fault_req) |=> (st_q == GATE_WAIT && busy));

  // R9
  end_drops_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end |=> !busy);
endmodule

// File: rtl/afs_halt_pulse.sv
module afs_halt_pulse #(
  parameter int N_DMA = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             sp_lsb,
  output logic             xfer_err_set,
  output logic             dma0_err_set,
  output logic [N_DMA-1:0] dma_en_clr,
  output logic             sp_odd
);
  logic pulse_q, odd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      odd_q   <= 1'b0;
    end else begin
      pulse_q <= go;
      if (go) odd_q <= sp_lsb;
    end
  end

  assign xfer_err_set = pulse_q;
  assign dma0_err_set = pulse_q;
  assign sp_odd       = odd_q;

  genvar g;
  generate
    for (g = 0; g < N_DMA; g++) begin : g_lane
      assign dma_en_clr[g] = pulse_q;
    end
  endgenerate

  // R5
  halt_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err_set |=> !xfer_err_set);

  // R11
  odd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (sp_odd == $past(sp_lsb)));
endmodule

// File: rtl/afs_status_unit.sv
module afs_status_unit
  import addr_fault_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              mode2,
  input  logic [SR_W-1:0]   ccr_in,
  input  logic [SR_W-1:0]   exr_in,
  input  logic              stack_done,
  output logic [2*SR_W-1:0] stack_word,
  output logic [SR_W-1:0]   ccr_out,
  output logic [SR_W-1:0]   exr_out
);
  logic [SR_W-1:0] ccr_snap_q, exr_snap_q;
  logic            mode2_q;

  assign stack_word = {ccr_snap_q, exr_snap_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_snap_q <= '0;
      exr_snap_q <= '0;
      mode2_q    <= 1'b0;
      ccr_out    <= '0;
      exr_out    <= '0;
    end else begin
      if (go) begin
        ccr_snap_q <= ccr_in;
        exr_snap_q <= exr_in;
        mode2_q    <= mode2;
      end
      if (stack_done) begin
        ccr_out <= ccr_after(ccr_snap_q);
        exr_out <= exr_after(exr_snap_q, mode2_q);
      end
    end
  end

  // R6
  ccr_ui_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_done |=> (ccr_out[7] && ccr_out[6] == $past(ccr_snap_q[6])));

  // R7
  exr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stack_done && mode2_q) |=> (exr_out[2:0] == 3'b111 && !exr_out[7]));
endmodule

// File: rtl/afs_mem_engine.sv
module afs_mem_engine
  import addr_fault_pkg::*;
#(
  parameter int                PC_W     = 32,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [2*SR_W-1:0] stack_word,
  input  logic              mem_ready,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              stack_done,
  output logic              seq_end,
  output logic [PC_W-1:0]   pc_out,
  output logic              pc_load,
  output logic [ADDR_W-1:0] sp_out
);
  localparam int PC_WORDS = PC_W / WORD_W;
  localparam int IDX_W    = $clog2(PC_WORDS + 1);
  localparam logic [IDX_W-1:0] LAST_PUSH  = IDX_W'(PC_WORDS);
  localparam logic [IDX_W-1:0] LAST_FETCH = IDX_W'(PC_WORDS - 1);

  eng_st_t           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [PC_W-1:0]   pc_snap_q, pc_acc_q;
  logic [ADDR_W-1:0] sp_q;
  logic [WORD_W-1:0] pc_word;
  logic              push_ack, fetch_ack;

  // select the PC word for the current push, lowest word first
  always_comb begin
    pc_word = '0;
    for (int k = 0; k < PC_WORDS; k++)
      if (idx_q == IDX_W'(k)) pc_word = pc_snap_q[k*WORD_W +: WORD_W];
  end

  assign mem_wr_en  = (st_q == ENG_PUSH);
  assign mem_rd_en  = (st_q == ENG_FETCH);
  assign mem_addr   = mem_wr_en ? push_slot(sp_q) : vec_slot(VEC_ADDR, idx_q);
  assign mem_wdata  = !mem_wr_en ? '0 : ((idx_q == LAST_PUSH) ? stack_word : pc_word);
  assign push_ack   = mem_wr_en & mem_ready;
  assign fetch_ack  = mem_rd_en & mem_ready;
  assign stack_done = push_ack && (idx_q == LAST_PUSH);
  assign seq_end    = fetch_ack && (idx_q == LAST_FETCH);
  assign pc_out     = pc_acc_q;
  assign sp_out     = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ENG_IDLE;
      idx_q     <= '0;
      sp_q      <= '0;
      pc_snap_q <= '0;
      pc_acc_q  <= '0;
      pc_load   <= 1'b0;
    end else begin
      pc_load <= seq_end;
      unique case (st_q)
        ENG_IDLE: if (go) begin
          st_q      <= ENG_PUSH;
          idx_q     <= '0;
          sp_q      <= sp_in;
          pc_snap_q <= pc_in;
        end
        ENG_PUSH: if (push_ack) begin
          sp_q <= push_slot(sp_q);
          if (idx_q == LAST_PUSH) begin
            st_q  <= ENG_FETCH;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ENG_FETCH: if (fetch_ack) begin
          if (idx_q == LAST_FETCH) begin
            st_q  <= ENG_IDLE;
            idx_q <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
      // vector words arrive highest first
      for (int k = 0; k < PC_WORDS; k++)
        if (fetch_ack && idx_q == IDX_W'(PC_WORDS - 1 - k))
          pc_acc_q[k*WORD_W +: WORD_W] <= mem_rdata;
    end
  end

  // R3
  wr_rd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && mem_rd_en));

  // R3
  push_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ack && idx_q != LAST_PUSH) |=>
      (mem_wr_en && mem_addr == $past(mem_addr) - ADDR_W'(WORD_BYTES)));

  // R4
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_ready) |=>
      (mem_wr_en && $stable(mem_addr) && $stable(mem_wdata)));

  // R4
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !mem_ready) |=> (mem_rd_en && $stable(mem_addr)));

  // R8
  fetch_after_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stack_done |=> (mem_rd_en && mem_addr == VEC_ADDR));

  // R9
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);
endmodule

// File: rtl/addr_fault_seq.sv
module addr_fault_seq
  import addr_fault_pkg::*;
#(
  parameter int                PC_W     = 32,
  parameter int                N_DMA    = 4,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h0010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_req,
  input  logic              bus_end,
  input  logic              insn_end,
  input  logic              intr_mode2,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [SR_W-1:0]   ccr_in,
  input  logic [SR_W-1:0]   exr_in,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              mem_wr_en,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic              busy,
  output logic [PC_W-1:0]   pc_out,
  output logic              pc_load,
  output logic [SR_W-1:0]   ccr_out,
  output logic [SR_W-1:0]   exr_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic              sp_odd,
  output logic              xfer_err_set,
  output logic              dma0_err_set,
  output logic [N_DMA-1:0]  dma_en_clr
);
  // internal events, named for the checks
  logic              go;
  logic              stack_done;
  logic              seq_end;
  logic [2*SR_W-1:0] stack_word;

  afs_entry_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_req(fault_req),
    .bus_end  (bus_end),
    .insn_end (insn_end),
    .seq_end  (seq_end),
    .go       (go),
    .busy     (busy)
  );

  afs_halt_pulse #(.N_DMA(N_DMA)) u_halt (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .sp_lsb      (sp_in[0]),
    .xfer_err_set(xfer_err_set),
    .dma0_err_set(dma0_err_set),
    .dma_en_clr  (dma_en_clr),
    .sp_odd      (sp_odd)
  );

  afs_status_unit u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .mode2     (intr_mode2),
    .ccr_in    (ccr_in),
    .exr_in    (exr_in),
    .stack_done(stack_done),
    .stack_word(stack_word),
    .ccr_out   (ccr_out),
    .exr_out   (exr_out)
  );

  afs_mem_engine #(.PC_W(PC_W), .VEC_ADDR(VEC_ADDR)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .pc_in     (pc_in),
    .sp_in     (sp_in),
    .stack_word(stack_word),
    .mem_ready (mem_ready),
    .mem_rdata (mem_rdata),
    .mem_wr_en (mem_wr_en),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .stack_done(stack_done),
    .seq_end   (seq_end),
    .pc_out    (pc_out),
    .pc_load   (pc_load),
    .sp_out    (sp_out)
  );

  // R5
  halt_at_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err_set |-> (mem_wr_en && busy && dma0_err_set && (&dma_en_clr)));

  // R2
  quiet_until_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_wr_en && !mem_rd_en));
endmodule

// File: tb/addr_fault_seq_tb_top.sv
`timescale 1ns/1ps
module addr_fault_seq_tb_top;
  localparam int          N_DMA = 4;
  localparam logic [15:0] VEC   = 16'h0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_req = 1'b0, bus_end = 1'b0, insn_end = 1'b0, intr_mode2 = 1'b0;
  logic [31:0] pc_in = '0;
  logic [7:0]  ccr_in = '0, exr_in = '0;
  logic [15:0] sp_in = '0;
  logic        mem_wr_en, mem_rd_en, mem_ready = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        busy, pc_load, sp_odd, xfer_err_set, dma0_err_set;
  logic [31:0] pc_out;
  logic [7:0]  ccr_out, exr_out;
  logic [15:0] sp_out;
  logic [N_DMA-1:0] dma_en_clr;

  always #4 clk = ~clk;

  addr_fault_seq dut_i (
    .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .bus_end(bus_end),
    .insn_end(insn_end), .intr_mode2(intr_mode2), .pc_in(pc_in), .ccr_in(ccr_in),
    .exr_in(exr_in), .sp_in(sp_in), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .busy(busy), .pc_out(pc_out), .pc_load(pc_load),
    .ccr_out(ccr_out), .exr_out(exr_out), .sp_out(sp_out), .sp_odd(sp_odd),
    .xfer_err_set(xfer_err_set), .dma0_err_set(dma0_err_set), .dma_en_clr(dma_en_clr)
  );

  typedef struct packed { logic wr; logic [15:0] addr; logic [15:0] data; logic chk_data; } acc_t;
  typedef struct packed { logic [31:0] pc; logic [7:0] ccr; logic [7:0] exr; logic [15:0] sp; logic odd; } fin_t;

  acc_t exp_q[$];
  fin_t fin_q[$];
  int n_chk = 0, n_fail = 0;
  int lat = 0, wcnt = 0, halt_seen = 0;
  logic [15:0] vec_hi = '0, vec_lo = '0, first_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model and monitor: pops expected accesses, checks halt and completion
  always @(negedge clk) begin
    mem_ready = 1'b0;
    if (rst_n && (mem_wr_en || mem_rd_en)) begin
      if (wcnt >= lat) begin
        acc_t e;
        mem_ready = 1'b1;
        wcnt = 0;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected access", {16'h0, mem_addr}, 32'h0);
        end else begin
          e = exp_q.pop_front();
          chk(mem_wr_en == e.wr, e.wr ? "R3" : "R8", "access kind", {31'h0, mem_wr_en}, {31'h0, e.wr});
          chk(mem_addr == e.addr, e.wr ? "R3" : "R8", "address", {16'h0, mem_addr}, {16'h0, e.addr});
          if (e.wr && e.chk_data)
            chk(mem_wdata == e.data, "R3", "stacked word", {16'h0, mem_wdata}, {16'h0, e.data});
          if (mem_rd_en) mem_rdata = (mem_addr == VEC) ? vec_hi : vec_lo;
        end
      end else begin
        wcnt++;
      end
    end
    if (rst_n && xfer_err_set) begin
      halt_seen++;
      chk(dma0_err_set && dma_en_clr == {N_DMA{1'b1}}, "R5", "halt lanes",
          {27'h0, dma0_err_set, dma_en_clr}, {27'h0, 1'b1, {N_DMA{1'b1}}});
      chk(mem_wr_en && mem_addr == first_addr, "R5", "halt in first stack cycle",
          {16'h0, mem_addr}, {16'h0, first_addr});
    end
    if (rst_n && pc_load) begin
      fin_t f;
      if (fin_q.size() == 0) begin
        chk(1'b0, "R10", "extra pc_load", 32'h1, 32'h0);
      end else begin
        f = fin_q.pop_front();
        chk(pc_out == f.pc, "R9", "pc_out", pc_out, f.pc);
        chk(sp_out == f.sp, "R9", "sp_out", {16'h0, sp_out}, {16'h0, f.sp});
        chk(!busy, "R9", "busy at load", {31'h0, busy}, 32'h0);
        chk(ccr_out == f.ccr, "R6", "ccr_out", {24'h0, ccr_out}, {24'h0, f.ccr});
        chk(exr_out == f.exr, "R7", "exr_out", {24'h0, exr_out}, {24'h0, f.exr});
        chk(sp_odd == f.odd, "R11", "sp_odd", {31'h0, sp_odd}, {31'h0, f.odd});
        chk(halt_seen == 1, "R5", "halt pulse count", halt_seen, 32'd1);
        chk(exp_q.size() == 0, "R10", "accesses left", exp_q.size(), 32'd0);
      end
      halt_seen = 0;
    end
  end

  // driver: queues the expected items, then raises the fault
  task automatic run_seq(input logic [31:0] pc, input logic [7:0] c, input logic [7:0] e,
                         input logic [15:0] sp, input bit m2, input int gb, input int gi,
                         input int lat_v, input bit nest, input logic [15:0] vh,
                         input logic [15:0] vl);
    bit   odd = sp[0];
    logic [7:0] ccr_x = {1'b1, c[6:0]};
    logic [7:0] exr_x = m2 ? {1'b0, e[6:3], 3'b111} : {1'b0, e[6:0]};
    int   last = (gb > gi) ? gb : gi;
    int   cyc = 0;
    lat = lat_v; vec_hi = vh; vec_lo = vl; first_addr = sp - 16'd2;
    exp_q.push_back('{1'b1, sp - 16'd2, pc[15:0], !odd});
    exp_q.push_back('{1'b1, sp - 16'd4, pc[31:16], !odd});
    exp_q.push_back('{1'b1, sp - 16'd6, {c, e}, !odd});
    exp_q.push_back('{1'b0, VEC, 16'h0, 1'b0});
    exp_q.push_back('{1'b0, VEC + 16'd2, 16'h0, 1'b0});
    fin_q.push_back('{{vh, vl}, ccr_x, exr_x, sp - 16'd6, odd});
    @(negedge clk);
    pc_in = pc; ccr_in = c; exr_in = e; sp_in = sp; intr_mode2 = m2;
    fault_req = 1'b1;
    @(negedge clk);
    fault_req = 1'b0;
    chk(busy, "R2", "busy after fault", {31'h0, busy}, 32'h1);
    for (int i = 0; i <= last; i++) begin
      chk(!mem_wr_en && !mem_rd_en && !xfer_err_set, "R2", "quiet before completion",
          {29'h0, mem_wr_en, mem_rd_en, xfer_err_set}, 32'h0);
      bus_end = (i == gb);
      insn_end = (i == gi);
      fault_req = nest && (i == 0);
      @(negedge clk);
    end
    bus_end = 1'b0; insn_end = 1'b0; fault_req = 1'b0;
    while (!pc_load) begin
      fault_req = nest && busy && (cyc % 2 == 0);
      cyc++;
      @(negedge clk);
    end
    fault_req = 1'b0;
    repeat (6) @(negedge clk);
    chk(!busy && !mem_wr_en && !mem_rd_en, "R10", "idle after sequence",
        {30'h0, busy, mem_wr_en | mem_rd_en}, 32'h0);
    chk(sp_odd == odd, "R11", "sp_odd held", {31'h0, sp_odd}, {31'h0, odd});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !pc_load && !mem_wr_en && !mem_rd_en, "R1", "reset outputs",
        {28'h0, busy, pc_load, mem_wr_en, mem_rd_en}, 32'h0);
    chk(!xfer_err_set && !dma0_err_set && dma_en_clr == '0, "R1", "reset halt lines",
        {27'h0, xfer_err_set, dma_en_clr}, 32'h0);
    run_seq(32'h0012_3456, 8'h45, 8'h05, 16'h8000, 1'b0, 0, 0, 0, 1'b0, 16'h0000, 16'h1200);
    run_seq(32'hA5A5_0F0F, 8'h3A, 8'h81, 16'h7FF0, 1'b1, 3, 1, 2, 1'b1, 16'h00AB, 16'hCDEF);
    run_seq(32'h0000_BEEF, 8'hC1, 8'hF2, 16'h6001, 1'b0, 2, 4, 1, 1'b0, 16'h0001, 16'h0002);
    run_seq(32'hFFFF_0002, 8'h00, 8'hFF, 16'h0006, 1'b1, 5, 0, 3, 1'b1, 16'h7777, 16'h8888);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule